// File: doc/BRIEF.md
# Two-wire slave address decoder

This block is the front end of a two-wire serial slave. It brings the clock and data lines into the system clock domain, finds START and STOP conditions, and shifts in the first byte after each START with the most significant bit first. It matches that byte against a fixed four-bit device code and decodes a three-bit selector into one of three internal targets: a memory array, a control/status register or a potentiometer bank. It also takes the direction bit from the byte.

When the address is valid, the block pulls the data line low for the acknowledge clock through an open-drain enable. It raises a one-hot target select and a direction flag, and pulses an accept strobe toward the downstream byte engines. The selects stay up until the next START or STOP. A write aimed at the memory or the potentiometers is refused unless an external write-enable latch input is high. A refused address gets no acknowledge, and the block ignores the bus until the next START.

Top module: `twi_addr_decoder`

## Requirements
- R1: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A START at any point, including part way through a byte or during a selected transaction, clears the selects and the acknowledge and restarts address capture.
- R2: The eight bits after START are taken on the rising clock edges, most significant bit first. Only a byte whose bits 7..4 equal 1010 can be accepted. Any other byte is not acknowledged, and later bytes are ignored until the next START.
- R3: The selector in bits 3..1 maps 000 to `sel_mem_o`, 010 to `sel_csr_o` and 111 to `sel_pot_o`. All other codes are not accepted. At most one select is high at any time.
- R4: `rw_o` takes bit 0 of an accepted byte, where 1 means read and 0 means write.
- R5: For an accepted byte, `sda_oe_o` (1 = pull the data line low) goes high after the falling clock edge that ends the eighth bit. It drops after the falling edge that ends the ninth clock. It is never high without a select.
- R6: `accept_o` is a one-cycle pulse, raised together with the select and the acknowledge.
- R7: Selects and `rw_o` hold their values until a START or STOP. A STOP clears them and returns the block to idle.
- R8: A write (bit 0 = 0) to the memory or potentiometer target is refused when `wr_en_i` is low at the decision: no acknowledge and no select. A write to the control/status target is accepted whatever `wr_en_i` is, and reads are never gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| wr_en_i | input | 1 | Write-enable latch state |
| sda_oe_o | output | 1 | 1 = drive data line low (acknowledge) |
| sel_mem_o | output | 1 | Memory array target selected |
| sel_csr_o | output | 1 | Control/status register selected |
| sel_pot_o | output | 1 | Potentiometer target selected |
| rw_o | output | 1 | Direction of accepted access, 1 = read |
| accept_o | output | 1 | One-cycle pulse on address accept |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, device code 1010 and selector codes 000, 010 and 111. At these values every selector code and both states of the write-enable input can be reached in a short run. The bench clocks the serial bus at eight system clocks per half period. That leaves room to see the acknowledge rise after the eighth falling edge and drop after the ninth, through the synchroniser delay. A repeated START part way through a byte and bytes sent after a refusal exercise the restart and ignore paths.

// File: rtl/twi_addr_pkg.sv
package twi_addr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_ACK,
    PH_HOLD,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic hit;
    logic mem;
    logic csr;
    logic pot;
  } tgt_t;

  // Match device code, decode selector, apply write-enable gate.
  function automatic tgt_t decode_addr(input logic [7:0] abyte,
                                       input logic [3:0] dev,
                                       input logic [2:0] c_mem,
                                       input logic [2:0] c_csr,
                                       input logic [2:0] c_pot,
                                       input logic       wel);
    tgt_t       t;
    logic [2:0] s;
    logic       wr;
    t  = '0;
    s  = abyte[3:1];
    wr = ~abyte[0];
    if (abyte[7:4] == dev) begin
      t.mem = (s == c_mem);
      t.csr = (s == c_csr);
      t.pot = (s == c_pot);
      if (wr && !wel) begin
        t.mem = 1'b0;
        t.pot = 1'b0;
      end
      t.hit = t.mem | t.csr | t.pot;
    end
    return t;
  endfunction

endpackage

// File: rtl/twi_sync_line.sv
module twi_sync_line #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff[0] <= RST_VAL;
        else        ff[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff[i] <= RST_VAL;
        else        ff[i] <= ff[i-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
endmodule

// File: rtl/twi_addr_fsm.sv
module twi_addr_fsm
  import twi_addr_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter logic [2:0] SEL_MEM  = 3'b000,
  parameter logic [2:0] SEL_CSR  = 3'b010,
  parameter logic [2:0] SEL_POT  = 3'b111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_s,
  input  logic wr_en_i,
  output logic sda_oe_o,
  output logic sel_mem_o,
  output logic sel_csr_o,
  output logic sel_pot_o,
  output logic rw_o,
  output logic accept_o
);
  localparam int ABITS = 8;
  localparam int CW    = $clog2(ABITS + 1);
  localparam logic [CW-1:0] LAST = CW'(ABITS);

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [ABITS-1:0] shreg;
  tgt_t            dec;

  assign dec = decode_addr(shreg, DEV_CODE, SEL_MEM, SEL_CSR, SEL_POT, wr_en_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      sda_oe_o  <= 1'b0;
      sel_mem_o <= 1'b0;
      sel_csr_o <= 1'b0;
      sel_pot_o <= 1'b0;
      rw_o      <= 1'b0;
      accept_o  <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      if (start_i || stop_i) begin
        phase     <= start_i ? PH_SHIFT : PH_IDLE;
        cnt       <= '0;
        sda_oe_o  <= 1'b0;
        sel_mem_o <= 1'b0;
        sel_csr_o <= 1'b0;
        sel_pot_o <= 1'b0;
        rw_o      <= 1'b0;
      end else begin
        case (phase)
          PH_SHIFT: begin
            if (scl_rise_i && cnt != LAST) begin
              shreg <= {shreg[ABITS-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == LAST) begin
              if (dec.hit) begin
                phase     <= PH_ACK;
                sda_oe_o  <= 1'b1;
                sel_mem_o <= dec.mem;
                sel_csr_o <= dec.csr;
                sel_pot_o <= dec.pot;
                rw_o      <= shreg[0];
                accept_o  <= 1'b1;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              phase    <= PH_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/twi_addr_decoder.sv
module twi_addr_decoder #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter logic [2:0] SEL_MEM     = 3'b000,
  parameter logic [2:0] SEL_CSR     = 3'b010,
  parameter logic [2:0] SEL_POT     = 3'b111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en_i,
  output logic sda_oe_o,
  output logic sel_mem_o,
  output logic sel_csr_o,
  output logic sel_pot_o,
  output logic rw_o,
  output logic accept_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, syn;
  logic start_w, stop_w, scl_rise_w, scl_fall_w;

  assign raw = {scl_i, sda_i};

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    twi_sync_line #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[k]), .q(syn[k])
    );
  end

  twi_bus_events u_events (
    .clk(clk), .rst_n(rst_n),
    .scl_s(syn[1]), .sda_s(syn[0]),
    .start_o(start_w), .stop_o(stop_w),
    .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w)
  );

  twi_addr_fsm #(
    .DEV_CODE(DEV_CODE), .SEL_MEM(SEL_MEM), .SEL_CSR(SEL_CSR), .SEL_POT(SEL_POT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_w), .stop_i(stop_w),
    .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
    .sda_s(syn[0]), .wr_en_i(wr_en_i),
    .sda_oe_o(sda_oe_o), .sel_mem_o(sel_mem_o), .sel_csr_o(sel_csr_o),
    .sel_pot_o(sel_pot_o), .rw_o(rw_o), .accept_o(accept_o)
  );
endmodule

// File: rtl/twi_addr_decoder_chk.sv
module twi_addr_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic stop_evt,
  input logic scl_fall_evt,
  input logic wr_en,
  input logic sda_oe,
  input logic sel_mem,
  input logic sel_csr,
  input logic sel_pot,
  input logic rw,
  input logic accept
);
  logic any_sel;
  assign any_sel = sel_mem | sel_csr | sel_pot;

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_mem, sel_csr, sel_pot}));

  assert_ack_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> any_sel);

  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe && scl_fall_evt |=> !sda_oe);

  assert_accept_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  assert_accept_with_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> any_sel && sda_oe);

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !any_sel && !sda_oe);

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel && !start_evt && !stop_evt |=> $stable({sel_mem, sel_csr, sel_pot, rw}));

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !any_sel && !sda_oe);

  assert_wel_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !rw && (sel_mem || sel_pot) |-> $past(wr_en));
endmodule

bind twi_addr_decoder twi_addr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_evt(start_w), .stop_evt(stop_w), .scl_fall_evt(scl_fall_w),
  .wr_en(wr_en_i), .sda_oe(sda_oe_o),
  .sel_mem(sel_mem_o), .sel_csr(sel_csr_o), .sel_pot(sel_pot_o),
  .rw(rw_o), .accept(accept_o)
);

// File: tb/twi_addr_decoder_bench.sv
module twi_addr_decoder_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wel = 1'b0;
  wire  sda_bus;
  logic sda_oe_o, sel_mem_o, sel_csr_o, sel_pot_o, rw_o, accept_o;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe_o;

  twi_addr_decoder u_twi_addr_decoder (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wr_en_i(wel),
    .sda_oe_o(sda_oe_o), .sel_mem_o(sel_mem_o), .sel_csr_o(sel_csr_o),
    .sel_pot_o(sel_pot_o), .rw_o(rw_o), .accept_o(accept_o)
  );

  // ---- behavioural reference model ----
  int mph = 0;            // 0 idle, 1 shifting, 2 acking, 3 selected, 4 ignoring
  int mbits = 0;
  int maddr = 0;
  bit a1, a2, ap, d1, d2, dp;
  bit x_oe, x_mem, x_csr, x_pot, x_rw, x_stb;
  bit ev_st, ev_sp, ev_rs, ev_fl;
  int typ, sel, rd;
  bit okay;

  always @(posedge clk) begin
    if (!rst_n) begin
      a1 = 1; a2 = 1; ap = 1; d1 = 1; d2 = 1; dp = 1;
      mph = 0; mbits = 0; maddr = 0;
      {x_oe, x_mem, x_csr, x_pot, x_rw, x_stb} = '0;
    end else begin
      ev_st = a2 && ap && dp && !d2;
      ev_sp = a2 && ap && !dp && d2;
      ev_rs = a2 && !ap;
      ev_fl = !a2 && ap;
      x_stb = 0;
      if (ev_st || ev_sp) begin
        mph = ev_st ? 1 : 0;
        mbits = 0;
        {x_oe, x_mem, x_csr, x_pot, x_rw} = '0;
      end else if (mph == 1) begin
        if (ev_rs && mbits < 8) begin
          maddr = ((maddr * 2) + int'(d2)) % 256;
          mbits++;
        end else if (ev_fl && mbits == 8) begin
          typ = maddr / 16; sel = (maddr / 2) % 8; rd = maddr % 2;
          okay = (typ == 10) && (sel == 0 || sel == 2 || sel == 7);
          if (okay && rd == 0 && sel != 2 && !wel) okay = 0;
          if (okay) begin
            mph = 2; x_oe = 1; x_stb = 1; x_rw = (rd == 1);
            x_mem = (sel == 0); x_csr = (sel == 2); x_pot = (sel == 7);
          end else mph = 4;
        end
      end else if (mph == 2 && ev_fl) begin
        x_oe = 0; mph = 3;
      end
      ap = a2; a2 = a1; a1 = scl;
      dp = d2; d2 = d1; d1 = sda_bus;
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(sda_oe_o == x_oe, "R5 ack drive", sda_oe_o, x_oe);
      chk({sel_mem_o, sel_csr_o, sel_pot_o} == {x_mem, x_csr, x_pot}, "R3 selects",
          {sel_mem_o, sel_csr_o, sel_pot_o}, {x_mem, x_csr, x_pot});
      chk(rw_o == x_rw, "R4 direction", rw_o, x_rw);
      chk(accept_o == x_stb, "R6 accept", accept_o, x_stb);
      if (accept_o) strobes++;
    end
  end

  // ---- bus driver ----
  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    scl = 0; hw(HALF); sda_m = 1; hw(HALF); scl = 1; hw(HALF);
    sda_m = 0; hw(HALF); scl = 0; hw(HALF);
  endtask

  task automatic do_stop();
    scl = 0; sda_m = 0; hw(HALF); scl = 1; hw(HALF); sda_m = 1; hw(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(HALF); scl = 1; hw(HALF); scl = 0; hw(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; hw(HALF); scl = 1; hw(HALF / 2);
    ack = !sda_bus;
    hw(HALF / 2); scl = 0; hw(HALF);
  endtask

  task automatic addr_case(input logic [7:0] a, input bit w, input bit exp_ack,
                           input logic [2:0] exp_sel, input string tag);
    bit ack;
    int s0;
    wel = w;
    s0 = strobes;
    do_start();
    send_byte(a, ack);
    chk(ack == exp_ack, tag, ack, exp_ack);
    chk({sel_mem_o, sel_csr_o, sel_pot_o} == exp_sel, tag,
        {sel_mem_o, sel_csr_o, sel_pot_o}, exp_sel);
    chk(strobes - s0 == int'(exp_ack), "R6 one accept pulse", strobes - s0, int'(exp_ack));
    chk(sda_oe_o == 1'b0, "R5 released after ninth clock", sda_oe_o, 0);
  endtask

  initial begin
    bit ack;
    hw(5);
    chk({sda_oe_o, sel_mem_o, sel_csr_o, sel_pot_o, rw_o, accept_o} == '0,
        "R7 reset state", {sda_oe_o, sel_mem_o, sel_csr_o, sel_pot_o, rw_o, accept_o}, 0);
    rst_n = 1; hw(5);

    // R2 R3 R4: memory write with latch set, 1010_000_0
    addr_case(8'hA0, 1, 1, 3'b100, "R2 memory write accepted");
    chk(rw_o == 0, "R4 write direction", rw_o, 0);
    send_byte(8'h55, ack);
    chk(ack == 0 && sel_mem_o == 1, "R7 data byte keeps select", sel_mem_o, 1);
    do_stop(); hw(4);
    chk(sel_mem_o == 0, "R7 stop clears select", sel_mem_o, 0);

    // R8: memory and pot writes refused without latch, csr accepted
    addr_case(8'hA0, 0, 0, 3'b000, "R8 memory write blocked");
    do_stop();
    addr_case(8'hAE, 0, 0, 3'b000, "R8 pot write blocked");
    do_stop();
    addr_case(8'hA4, 0, 1, 3'b010, "R8 csr write not gated");
    do_stop();
    addr_case(8'hAF, 0, 1, 3'b001, "R4 pot read accepted");
    chk(rw_o == 1, "R4 read direction", rw_o, 1);
    do_stop();
    addr_case(8'hA5, 1, 1, 3'b010, "R3 csr read");
    do_stop();

    // R2: wrong device code, then a valid-looking byte without START
    addr_case(8'hB0, 1, 0, 3'b000, "R2 wrong device code");
    send_byte(8'hA0, ack);
    chk(ack == 0, "R2 ignored until START", ack, 0);
    do_stop();
    addr_case(8'h20, 1, 0, 3'b000, "R2 wrong device code low");
    do_stop();

    // R3: unused selector codes
    addr_case(8'hA2, 1, 0, 3'b000, "R3 selector 001 refused");
    do_stop();
    addr_case(8'hAC, 1, 0, 3'b000, "R3 selector 110 refused");
    do_stop();

    // R1: repeated START mid-byte, then during a selected transaction
    wel = 1;
    do_start();
    send_bits(8'hB3, 4);
    addr_case(8'hAE, 1, 1, 3'b001, "R1 restart mid byte");
    do_start();
    chk({sel_mem_o, sel_csr_o, sel_pot_o} == 0, "R1 start clears select",
        {sel_mem_o, sel_csr_o, sel_pot_o}, 0);
    send_byte(8'hA1, ack);
    chk(ack == 1 && sel_mem_o == 1 && rw_o == 1, "R1 repeated start recapture",
        {ack, sel_mem_o, rw_o}, 7);
    do_stop(); hw(10);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule